// File: doc/BRIEF.md
# Serial-Port FIFO Control Register

This block is the write-only control register that sits in front of a pair of byte FIFOs in a serial port, one for received bytes and one for bytes waiting to be sent. A bus write drives a global FIFO enable, stores a two-bit trigger selection for each direction, and can request a one-cycle clear of either FIFO's pointers and level counter. The clear requests are not stored: they act once and drop back to zero by themselves.

A write takes effect only when bit 0 of that same write is 1. If bit 0 is 0, the write only turns the FIFOs off, and every other bit is discarded. While the FIFOs are off they are held empty, so turning them on again always starts from an empty state. Each FIFO holds 128 bytes. It reports its level, empty and full flags, and a trigger flag. The trigger flag is set when the level is at or above the threshold picked by the stored selection. The clear acts only on pointers and counters. The serial shift registers are outside this block and a clear does not reach them.

Top module: `fifo_ctl_top`

## Requirements
- R1: After reset, `fifo_on` is 0, both reset pulses are 0, both trigger selections are 0, and both FIFOs report level 0 with `empty`=1 and `full`=0.
- R2: A write with bit 0 = 1 sets `fifo_on` to 1 on the write edge. It also stores bits [7:6] as the receive trigger selection and bits [5:4] as the transmit trigger selection.
- R3: A write with bit 0 = 0 clears `fifo_on`. Bits [7:1] of that write are ignored: both trigger selections keep their values and neither reset pulse is raised.
- R4: A write with bits 0 and 1 both 1 raises `rx_rst_pulse` for exactly the one cycle after the write edge. The receive FIFO level reads 0 after the next edge. The transmit FIFO is unchanged.
- R5: A write with bits 0 and 2 both 1 raises `tx_rst_pulse` for exactly the one cycle after the write edge. The transmit FIFO level reads 0 after the next edge. The receive FIFO is unchanged.
- R6: The reset bits are not stored. A pulse ends after one cycle without any further write. A later enabled write with the reset bit at 0 raises no pulse.
- R7: A clear (reset pulse or FIFOs off) takes priority over a push or pop in the same cycle. The FIFO ends empty.
- R8: While `fifo_on` is 0, both FIFOs stay empty and pushes have no effect. After the FIFOs are turned on again, both start at level 0.
- R9: Each FIFO returns bytes in the order they were pushed and holds up to 128 of them. A push while full is ignored unless a pop happens in the same cycle. A pop while empty is ignored.
- R10: `empty` is 1 exactly at level 0 and `full` is 1 exactly at level 128. `trig` is 1 when the level is at or above the threshold for the selection: 0→1, 1→32, 2→64, 3→120.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| fifo_on | output | 1 | Global FIFO enable |
| rx_rst_pulse | output | 1 | One-cycle receive FIFO clear |
| tx_rst_pulse | output | 1 | One-cycle transmit FIFO clear |
| rx_trig_sel | output | 2 | Stored receive trigger selection |
| tx_trig_sel | output | 2 | Stored transmit trigger selection |
| rx_push | input | 1 | Push a byte into the receive FIFO |
| rx_din | input | 8 | Byte to push into the receive FIFO |
| rx_pop | input | 1 | Pop the head of the receive FIFO |
| rx_dout | output | 8 | Head byte of the receive FIFO |
| rx_level | output | 8 | Receive FIFO level (0..128) |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_trig | output | 1 | Receive level at or above threshold |
| tx_push | input | 1 | Push a byte into the transmit FIFO |
| tx_din | input | 8 | Byte to push into the transmit FIFO |
| tx_pop | input | 1 | Pop the head of the transmit FIFO |
| tx_dout | output | 8 | Head byte of the transmit FIFO |
| tx_level | output | 8 | Transmit FIFO level (0..128) |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_trig | output | 1 | Transmit level at or above threshold |

## Verification
Two functions can land in the same cycle: the receive FIFO clear driven by the reset pulse, and a byte push into that same FIFO. The bench loads a few bytes, writes the reset request, and then asserts a push during the exact cycle in which the pulse is high. It judges the result by the receive level, which must read 0, and by `empty`, which must read 1, after that edge. The same clear-over-push rule is checked with the FIFOs off: pushes made while `fifo_on` is 0 must leave the level at 0.

// File: rtl/fifo_ctl_pkg.sv
package fifo_ctl_pkg;
  localparam int EN_BIT    = 0;
  localparam int RXRST_BIT = 1;
  localparam int TXRST_BIT = 2;
  localparam int TXSEL_LSB = 4;
  localparam int RXSEL_LSB = 6;

  // threshold picked by a two-bit selection, scaled to the FIFO depth
  function automatic int unsigned trig_threshold(int unsigned depth, logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - depth / 16;
    endcase
  endfunction

  // level after one cycle of push/pop activity
  function automatic int unsigned level_step(int unsigned lvl, logic inc, logic dec);
    return lvl + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction
endpackage

// File: rtl/fifo_ctl_reg.sv
module fifo_ctl_reg
  import fifo_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          fifo_on,
  output logic          rx_rst,
  output logic          tx_rst,
  output logic [1:0]    rx_sel,
  output logic [1:0]    tx_sel
);
  logic wr_accept;
  logic wr_disable;

  assign wr_accept  = wr_en &  wr_data[EN_BIT];
  assign wr_disable = wr_en & ~wr_data[EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_on <= 1'b0;
      rx_sel  <= 2'd0;
      tx_sel  <= 2'd0;
    end else if (wr_accept) begin
      fifo_on <= 1'b1;
      rx_sel  <= wr_data[RXSEL_LSB +: 2];
      tx_sel  <= wr_data[TXSEL_LSB +: 2];
    end else if (wr_disable) begin
      fifo_on <= 1'b0;
    end
  end

  // reset requests are never held: each is a single registered pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rst <= 1'b0;
      tx_rst <= 1'b0;
    end else begin
      rx_rst <= wr_accept & wr_data[RXRST_BIT];
      tx_rst <= wr_accept & wr_data[TXRST_BIT];
    end
  end

  AST_RX_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |-> $past(wr_en && wr_data[EN_BIT] && wr_data[RXRST_BIT])); // R4
  AST_TX_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |-> $past(wr_en && wr_data[EN_BIT] && wr_data[TXRST_BIT])); // R5
  AST_DISABLE_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_disable |=> !fifo_on && $stable(rx_sel) && $stable(tx_sel) && !rx_rst && !tx_rst); // R3
  AST_ACCEPT_SETS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> fifo_on); // R2
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo
  import fifo_ctl_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [1:0]    trig_sel,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          trig
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_push;
  logic          do_pop;
  int unsigned   thr;

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign thr     = trig_threshold(DEPTH, trig_sel);
  assign trig    = 32'(level) >= thr;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      level <= CW'(level_step(32'(level), do_push, do_pop));
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> level == '0); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !clr |=> full); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push && !clr |=> empty); // R9
endmodule

// File: rtl/fifo_ctl_top.sv
module fifo_ctl_top
  import fifo_ctl_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic          fifo_on,
  output logic          rx_rst_pulse,
  output logic          tx_rst_pulse,
  output logic [1:0]    rx_trig_sel,
  output logic [1:0]    tx_trig_sel,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_din,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_dout,
  output logic [CW-1:0] rx_level,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          rx_trig,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_din,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_dout,
  output logic [CW-1:0] tx_level,
  output logic          tx_empty,
  output logic          tx_full,
  output logic          tx_trig
);
  logic rx_clr;
  logic tx_clr;

  fifo_ctl_reg #(.DW(8)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_on(fifo_on), .rx_rst(rx_rst_pulse), .tx_rst(tx_rst_pulse),
    .rx_sel(rx_trig_sel), .tx_sel(tx_trig_sel)
  );

  // FIFOs off means held empty, so turning them on starts clean
  assign rx_clr = rx_rst_pulse | ~fifo_on;
  assign tx_clr = tx_rst_pulse | ~fifo_on;

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .trig_sel(rx_trig_sel),
    .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
    .level(rx_level), .empty(rx_empty), .full(rx_full), .trig(rx_trig)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .trig_sel(tx_trig_sel),
    .push(tx_push), .din(tx_din), .pop(tx_pop), .dout(tx_dout),
    .level(tx_level), .empty(tx_empty), .full(tx_full), .trig(tx_trig)
  );

  AST_OFF_HOLDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on |=> rx_level == '0 && tx_level == '0); // R8
  AST_RX_RST_SPARES_TX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_pulse && !tx_rst_pulse && fifo_on && !tx_push && !tx_pop |=> $stable(tx_level)); // R4
endmodule

// File: tb/fifo_ctl_top_test.sv
`timescale 1ns/1ps
module fifo_ctl_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_din = 8'h00, tx_din = 8'h00;
  logic       fifo_on, rx_rst_pulse, tx_rst_pulse;
  logic [1:0] rx_trig_sel, tx_trig_sel;
  logic [7:0] rx_dout, tx_dout, rx_level, tx_level;
  logic       rx_empty, rx_full, rx_trig, tx_empty, tx_full, tx_trig;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fifo_ctl_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_on(fifo_on), .rx_rst_pulse(rx_rst_pulse), .tx_rst_pulse(tx_rst_pulse),
    .rx_trig_sel(rx_trig_sel), .tx_trig_sel(tx_trig_sel),
    .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
    .rx_level(rx_level), .rx_empty(rx_empty), .rx_full(rx_full), .rx_trig(rx_trig),
    .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
    .tx_level(tx_level), .tx_empty(tx_empty), .tx_full(tx_full), .tx_trig(tx_trig)
  );

  // {wr, data[7:0], on, rx_sel[1:0], tx_sel[1:0], rx_pulse, tx_pulse}
  localparam logic [15:0] VEC [8] = '{
    {1'b1, 8'hB1, 1'b1, 2'd2, 2'd3, 1'b0, 1'b0},
    {1'b1, 8'hF6, 1'b0, 2'd2, 2'd3, 1'b0, 1'b0},
    {1'b1, 8'h53, 1'b1, 2'd1, 2'd1, 1'b1, 1'b0},
    {1'b0, 8'hFF, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0},
    {1'b1, 8'h05, 1'b1, 2'd0, 2'd0, 1'b0, 1'b1},
    {1'b1, 8'hE7, 1'b1, 2'd3, 2'd2, 1'b1, 1'b1},
    {1'b1, 8'h01, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0},
    {1'b1, 8'h00, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0}
  };

  function automatic int exp_thr(logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 32;
      2'd2: return 64;
      default: return 120;
    endcase
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic push_rx(logic [7:0] b);
    rx_push = 1'b1; rx_din = b; cyc(); rx_push = 1'b0;
  endtask

  task automatic push_tx(logic [7:0] b);
    tx_push = 1'b1; tx_din = b; cyc(); tx_push = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 on", fifo_on, 0);
    check("R1 pulses", {rx_rst_pulse, tx_rst_pulse}, 0);
    check("R1 sel", {rx_trig_sel, tx_trig_sel}, 0);
    check("R1 rx", {rx_level, rx_empty, rx_full}, {8'd0, 1'b1, 1'b0});
    check("R1 tx", {tx_level, tx_empty, tx_full}, {8'd0, 1'b1, 1'b0});

    // table walk: R2 R3 R6 and pulse timing of R4 R5
    for (int i = 0; i < 8; i++) begin
      wr_en = VEC[i][15]; wr_data = VEC[i][14:7];
      cyc();
      wr_en = 1'b0;
      check("R2/R3 on", fifo_on, VEC[i][6]);
      check("R2/R3 rx_sel", rx_trig_sel, VEC[i][5:4]);
      check("R2/R3 tx_sel", tx_trig_sel, VEC[i][3:2]);
      check("R4/R6 rx pulse", rx_rst_pulse, VEC[i][1]);
      check("R5/R6 tx pulse", tx_rst_pulse, VEC[i][0]);
    end

    // R9 R10: fill rx with selection 3, tx selection 1
    wr_reg(8'hD1);
    check("R2 sel", {rx_trig_sel, tx_trig_sel}, {2'd3, 2'd1});
    check("R10 trig at 0", rx_trig, 0);
    for (int i = 0; i < 128; i++) begin
      push_rx(8'(i));
      check("R10 rx trig", rx_trig, int'((i + 1) >= exp_thr(2'd3)));
      check("R9 rx level", rx_level, i + 1);
    end
    check("R10 full", {rx_full, rx_empty}, {1'b1, 1'b0});
    push_rx(8'hEE);
    check("R9 push while full", rx_level, 128);
    check("R9 head kept", rx_dout, 0);
    // push and pop together when full
    rx_push = 1'b1; rx_pop = 1'b1; rx_din = 8'h5A; cyc(); rx_push = 1'b0; rx_pop = 1'b0;
    check("R9 full push+pop level", rx_level, 128);
    for (int i = 1; i < 128; i++) begin
      check("R9 order", rx_dout, i);
      rx_pop = 1'b1; cyc(); rx_pop = 1'b0;
    end
    check("R9 last byte", rx_dout, 8'h5A);
    rx_pop = 1'b1; cyc(); cyc(); rx_pop = 1'b0;
    check("R9 pop while empty", {rx_level, rx_empty}, {8'd0, 1'b1});

    for (int i = 0; i < 32; i++) begin
      check("R10 tx trig", tx_trig, int'(i >= exp_thr(2'd1)));
      push_tx(8'(i + 100));
    end
    check("R10 tx trig at 32", tx_trig, 1);

    // R4: rx reset leaves tx alone
    for (int i = 0; i < 5; i++) push_rx(8'(i));
    wr_reg(8'hD3);
    check("R4 pulse", rx_rst_pulse, 1);
    cyc();
    check("R4 rx cleared", {rx_level, rx_empty}, {8'd0, 1'b1});
    check("R4 tx kept", tx_level, 32);
    check("R6 pulse dropped", rx_rst_pulse, 0);

    // R5: tx reset leaves rx alone
    for (int i = 0; i < 3; i++) push_rx(8'(i + 7));
    wr_reg(8'hD5);
    cyc();
    check("R5 tx cleared", {tx_level, tx_empty}, {8'd0, 1'b1});
    check("R5 rx kept", rx_level, 3);
    check("R5 rx head", rx_dout, 7);

    // R7: push in the pulse cycle loses to the clear
    wr_reg(8'hD3);
    rx_push = 1'b1; rx_din = 8'h77; cyc(); rx_push = 1'b0;
    check("R7 clear over push", {rx_level, rx_empty}, {8'd0, 1'b1});

    // R8 / R3: disable empties, pushes ignored, selections kept
    push_rx(8'h11); push_tx(8'h22);
    wr_reg(8'h06);
    check("R3 off", fifo_on, 0);
    check("R3 no pulses", {rx_rst_pulse, tx_rst_pulse}, 0);
    check("R3 sel kept", {rx_trig_sel, tx_trig_sel}, {2'd3, 2'd1});
    cyc();
    check("R8 emptied", {rx_level, tx_level}, 0);
    push_rx(8'h33); push_tx(8'h44);
    check("R8 push ignored", {rx_level, tx_level}, 0);
    wr_reg(8'h01);
    check("R8 on again empty", {rx_level, tx_level, rx_empty, tx_empty}, {16'd0, 2'b11});
    push_rx(8'h99);
    check("R8 works after on", {rx_level, rx_dout}, {8'd1, 8'h99});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule